// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits beside a parallel memory array and watches every completed bus operation. Each operation is presented for one clock cycle as a read/write flag, a 17-bit word address and the low data byte. The block looks for a fixed command sequence. First come six reads at exact addresses. Then a write carries a candidate protection byte. A second write must carry the bitwise complement of that byte, and a third write closes the sequence. When the complement matches, an 8-bit sector protection mask is loaded. Each mask bit guards one eighth of the address space.

Reads that form part of the sequence are still ordinary reads and return array data. The three sequence writes are consumed by the detector and are flagged so that the array controller drops them. A separate inhibit output combines that flag with the protection mask, which tells the controller whether the current write may reach the array. Retention of the mask across power loss is not modelled. The mask is a plain register that clears on reset.

Top module: `wp_unlock_detector`

## Requirements
- R1: After reset the protection mask is 00h and no write is flagged or inhibited.
- R2: Reads at 12555h, 1DAAAh, 01333h, 0ECCCh, 000FFh and 1FF00h, presented in that order, advance the sequence. A read is never flagged as a command write. A cycle with op_valid low changes nothing.
- R3: During the read phase, any write or any read at an address other than the expected one abandons the sequence. If that mismatching read is at 12555h, it counts as the first step of a new attempt.
- R4: A read of 00000h immediately before 12555h does not prevent the sequence from being recognised.
- R5: The first operation after the six reads must be a write. Its byte is held as the candidate value and the write is flagged. A seventh read abandons the sequence instead.
- R6: The next write is flagged. If its byte equals the bitwise complement of the candidate, the mask takes the candidate value at that clock edge. Any other byte leaves the mask unchanged and abandons the sequence.
- R7: After an accepted complement, the following write is flagged and ends the command. The operation after it (normally a read of 00000h) returns the block to normal operation. cmd_write is high only for these three sequence writes.
- R8: wr_inhibit is high for a valid write that is either flagged or targets a protected sector. Sector i is selected by address bits [16:14] = i, and mask bit i = 1 protects it.
- R9: The mask changes only on an accepted complement write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A completed bus operation is presented this cycle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_addr | input | 17 | Word address of the operation |
| op_byte | input | 8 | Low data byte of the operation |
| prot_mask | output | 8 | Per-sector protection mask, bit i guards sector i |
| cmd_write | output | 1 | Current write belongs to the unlock sequence |
| wr_inhibit | output | 1 | Current write must not reach the array |

## Verification
The bench targets several corner cases:
- A seventh read in place of the data write. A design that counted reads loosely would accept it and then load the next write's byte.
- A wrong complement. Mishandling it would load a mask that was never confirmed.
- A mismatched read at the entry address, and the leading read of 00000h. A design that only dropped back to idle would miss an otherwise valid sequence.
- Sector boundaries such as 0BFFFh/0C000h and 13FFFh/14000h. A wrong choice of address bits would inhibit the wrong sector.

Random traffic is biased toward sequence addresses and complement bytes, and it is checked against a reference model on every operation.

// File: rtl/wpsd_pkg.sv
package wpsd_pkg;

  localparam int KEY_AW = 17;
  localparam logic [KEY_AW-1:0] ENTRY_ADDR = 17'h12555;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_R1    = 4'd1,
    ST_R2    = 4'd2,
    ST_R3    = 4'd3,
    ST_R4    = 4'd4,
    ST_R5    = 4'd5,
    ST_WDATA = 4'd6,
    ST_WCPL  = 4'd7,
    ST_WLAST = 4'd8,
    ST_EXIT  = 4'd9
  } seq_e;

  // Address the next read must carry while in a read-phase state.
  function automatic logic [KEY_AW-1:0] key_addr(input seq_e s);
    case (s)
      ST_IDLE: key_addr = ENTRY_ADDR;
      ST_R1:   key_addr = 17'h1DAAA;
      ST_R2:   key_addr = 17'h01333;
      ST_R3:   key_addr = 17'h0ECCC;
      ST_R4:   key_addr = 17'h000FF;
      ST_R5:   key_addr = 17'h1FF00;
      default: key_addr = '0;
    endcase
  endfunction

endpackage

// File: rtl/wpsd_match.sv
module wpsd_match #(
  parameter int ADDR_W = 17
) (
  input  wpsd_pkg::seq_e    state,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              key_hit,
  output logic              entry_hit
);
  import wpsd_pkg::*;

  logic [ADDR_W-1:0] want;

  always_comb begin
    want      = ADDR_W'(key_addr(state));
    key_hit   = (op_addr == want);
    entry_hit = (op_addr == ADDR_W'(ENTRY_ADDR));
  end

endmodule

// File: rtl/wpsd_fsm.sv
module wpsd_fsm (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic           op_write,
  input  logic           key_hit,
  input  logic           entry_hit,
  input  logic           cpl_ok,
  output wpsd_pkg::seq_e state_q,
  output logic           cmd_write
);
  import wpsd_pkg::*;

  seq_e state_d;
  seq_e restart;
  logic in_cmd;

  always_comb begin
    restart = (!op_write && entry_hit) ? ST_R1 : ST_IDLE;
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_R1, ST_R2, ST_R3, ST_R4, ST_R5:
        state_d = (!op_write && key_hit) ? seq_e'(state_q + 4'd1) : restart;
      ST_WDATA: state_d = op_write ? ST_WCPL : restart;
      ST_WCPL:  state_d = op_write ? (cpl_ok ? ST_WLAST : ST_IDLE) : restart;
      ST_WLAST: state_d = op_write ? ST_EXIT : restart;
      ST_EXIT:  state_d = restart;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    in_cmd    = (state_q == ST_WDATA) || (state_q == ST_WCPL) ||
                (state_q == ST_WLAST);
    cmd_write = op_valid && op_write && in_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (op_valid) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/wpsd_guard.sv
module wpsd_guard #(
  parameter int ADDR_W = 17,
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [PROT_W-1:0] op_byte,
  input  wpsd_pkg::seq_e    state,
  input  logic              cmd_write,
  output logic [PROT_W-1:0] prot_mask,
  output logic              cpl_ok,
  output logic              wr_inhibit
);
  import wpsd_pkg::*;

  localparam int SECT_W = $clog2(PROT_W);

  logic [PROT_W-1:0] cand_q;
  logic [PROT_W-1:0] mask_q;
  logic [PROT_W-1:0] sect_hit;
  logic              load_cand;
  logic              load_mask;
  logic              hit_prot;

  for (genvar i = 0; i < PROT_W; i++) begin : g_sect
    assign sect_hit[i] = (op_addr[ADDR_W-1 -: SECT_W] == SECT_W'(i));
  end

  always_comb begin
    cpl_ok     = (op_byte == ~cand_q);
    load_cand  = op_valid && op_write && (state == ST_WDATA);
    load_mask  = op_valid && op_write && (state == ST_WCPL) && cpl_ok;
    hit_prot   = |(sect_hit & mask_q);
    wr_inhibit = op_valid && op_write && (cmd_write || hit_prot);
    prot_mask  = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
    end else if (load_cand) begin
      cand_q <= op_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load_mask) begin
      mask_q <= cand_q;
    end
  end

endmodule

// File: rtl/wp_unlock_detector.sv
module wp_unlock_detector #(
  parameter int ADDR_W = 17,
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [PROT_W-1:0] op_byte,
  output logic [PROT_W-1:0] prot_mask,
  output logic              cmd_write,
  output logic              wr_inhibit
);
  import wpsd_pkg::*;

  seq_e seq_state;
  logic key_hit;
  logic entry_hit;
  logic cpl_ok;

  wpsd_match #(.ADDR_W(ADDR_W)) u_match (
    .state     (seq_state),
    .op_addr   (op_addr),
    .key_hit   (key_hit),
    .entry_hit (entry_hit)
  );

  wpsd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_write  (op_write),
    .key_hit   (key_hit),
    .entry_hit (entry_hit),
    .cpl_ok    (cpl_ok),
    .state_q   (seq_state),
    .cmd_write (cmd_write)
  );

  wpsd_guard #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_write   (op_write),
    .op_addr    (op_addr),
    .op_byte    (op_byte),
    .state      (seq_state),
    .cmd_write  (cmd_write),
    .prot_mask  (prot_mask),
    .cpl_ok     (cpl_ok),
    .wr_inhibit (wr_inhibit)
  );

endmodule

// File: rtl/wpsd_checker.sv
module wpsd_checker #(
  parameter int PROT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_write,
  input logic [PROT_W-1:0] prot_mask,
  input logic              cmd_write,
  input logic              wr_inhibit,
  input wpsd_pkg::seq_e    seq_state
);
  import wpsd_pkg::*;

  // R9: mask holds unless a write lands in the complement stage
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_write && seq_state == ST_WCPL) |=> $stable(prot_mask));

  // R7: flag only on valid writes
  a_r7_cmd_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |-> (op_valid && op_write));

  // R8: a flagged write is always inhibited
  a_r8_cmd_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |-> wr_inhibit);

  // R3: a write during the read phase abandons the attempt
  a_r3_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write &&
     seq_state inside {ST_R1, ST_R2, ST_R3, ST_R4, ST_R5}) |=> seq_state == ST_IDLE);

  // R5: data write moves on to the complement stage
  a_r5_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && seq_state == ST_WDATA) |=> seq_state == ST_WCPL);

  // R6: complement write either proceeds or aborts
  a_r6_cpl_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && seq_state == ST_WCPL) |=>
      (seq_state == ST_WLAST || seq_state == ST_IDLE));

  // R2: idle bus cycles leave the sequence untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(seq_state));

endmodule

bind wp_unlock_detector wpsd_checker #(.PROT_W(PROT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_write   (op_write),
  .prot_mask  (prot_mask),
  .cmd_write  (cmd_write),
  .wr_inhibit (wr_inhibit),
  .seq_state  (seq_state)
);

// File: tb/tb_wp_unlock_detector.sv
module tb_wp_unlock_detector;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic        op_write;
  logic [16:0] op_addr;
  logic [7:0]  op_byte;
  logic [7:0]  prot_mask;
  logic        cmd_write;
  logic        wr_inhibit;

  int n_run;
  int n_fail;
  bit done;

  // reference model state
  int       m_st;
  bit [7:0] m_cand;
  bit [7:0] m_mask;

  wp_unlock_detector dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
    .op_addr(op_addr), .op_byte(op_byte), .prot_mask(prot_mask),
    .cmd_write(cmd_write), .wr_inhibit(wr_inhibit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit [16:0] key(input int k);
    case (k)
      0: key = 17'h12555;
      1: key = 17'h1DAAA;
      2: key = 17'h01333;
      3: key = 17'h0ECCC;
      4: key = 17'h000FF;
      default: key = 17'h1FF00;
    endcase
  endfunction

  function automatic int restart_of(input bit w, input bit [16:0] a);
    restart_of = (!w && a == key(0)) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bus operation: checks combinational flags, then mask after the edge
  task automatic do_op(input string tag, input bit w, input bit [16:0] a, input bit [7:0] d);
    bit exp_cmd;
    bit exp_inh;
    @(negedge clk);
    op_valid = 1'b1; op_write = w; op_addr = a; op_byte = d;
    #1;
    exp_cmd = w && (m_st >= 6 && m_st <= 8);
    exp_inh = w && (exp_cmd || m_mask[a[16:14]]);
    chk(tag, cmd_write, exp_cmd, "cmd_write");
    chk(tag, wr_inhibit, exp_inh, "wr_inhibit");
    case (m_st)
      0, 1, 2, 3, 4, 5: m_st = (!w && a == key(m_st)) ? m_st + 1 : restart_of(w, a);
      6: if (w) begin m_cand = d; m_st = 7; end else m_st = restart_of(w, a);
      7: if (w) begin
           if (d == ~m_cand) begin m_mask = m_cand; m_st = 8; end
           else m_st = 0;
         end else m_st = restart_of(w, a);
      8: m_st = w ? 9 : restart_of(w, a);
      default: m_st = restart_of(w, a);
    endcase
    @(posedge clk);
    #1;
    chk(tag, prot_mask, m_mask, "prot_mask");
  endtask

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    op_valid = 1'b0; op_write = 1'b1; op_addr = 17'h1DAAA; op_byte = 8'hFF;
    #1;
    chk(tag, cmd_write, 0, "cmd_write idle");
    @(posedge clk);
    #1;
    chk(tag, prot_mask, m_mask, "prot_mask idle");
  endtask

  task automatic six_reads(input string tag);
    for (int k = 0; k < 6; k++) do_op(tag, 1'b0, key(k), 8'h00);
  endtask

  task automatic full_seq(input string tag, input bit [7:0] v);
    six_reads(tag);
    do_op(tag, 1'b1, 17'h1DAAA, v);
    do_op(tag, 1'b1, 17'h0ECCC, ~v);
    do_op(tag, 1'b1, 17'h0FF00, 8'h5A);
    do_op(tag, 1'b0, 17'h00000, 8'h00);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    m_st = 0; m_cand = 0; m_mask = 0;
    void'($urandom(32'd1234));
    op_valid = 0; op_write = 0; op_addr = 0; op_byte = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", prot_mask, 0, "reset mask");
    chk("R1", cmd_write, 0, "reset cmd");
    chk("R1", wr_inhibit, 0, "reset inhibit");
    @(negedge clk);
    rst_n = 1;

    // R2/R6/R7: full sequence protecting sectors 3 and 4
    full_seq("R6", 8'h18);
    chk("R6", prot_mask, 8'h18, "mask after sequence");
    // R8: boundary addresses
    do_op("R8", 1'b1, 17'h0BFFF, 8'h11);
    do_op("R8", 1'b1, 17'h0C000, 8'h11);
    do_op("R8", 1'b1, 17'h13FFF, 8'h11);
    do_op("R8", 1'b1, 17'h14000, 8'h11);
    do_op("R8", 1'b0, 17'h0C000, 8'h11);

    // R4: leading read of 00000h
    do_op("R4", 1'b0, 17'h00000, 8'h00);
    full_seq("R4", 8'h81);
    chk("R4", prot_mask, 8'h81, "mask after pre-read");

    // R6: wrong complement leaves mask
    six_reads("R6");
    do_op("R6", 1'b1, 17'h1DAAA, 8'h55);
    do_op("R6", 1'b1, 17'h0ECCC, 8'h55);
    do_op("R7", 1'b1, 17'h0FF00, 8'h00);
    chk("R6", prot_mask, 8'h81, "mask after bad complement");

    // R5: seventh read aborts
    six_reads("R5");
    do_op("R5", 1'b0, 17'h1FF00, 8'h00);
    do_op("R5", 1'b1, 17'h1DAAA, 8'h00);
    do_op("R5", 1'b1, 17'h0ECCC, 8'hFF);
    chk("R5", prot_mask, 8'h81, "mask after seventh read");

    // R3: out of order, then restart through entry read
    do_op("R3", 1'b0, key(0), 8'h00);
    do_op("R3", 1'b0, key(2), 8'h00);
    do_op("R3", 1'b0, key(0), 8'h00);
    do_op("R3", 1'b0, key(1), 8'h00);
    do_op("R3", 1'b0, key(0), 8'h00);
    for (int k = 1; k < 6; k++) do_op("R3", 1'b0, key(k), 8'h00);
    do_op("R3", 1'b1, 17'h1DAAA, 8'h0F);
    do_op("R3", 1'b1, 17'h0ECCC, 8'hF0);
    do_op("R3", 1'b1, 17'h0FF00, 8'h00);
    chk("R3", prot_mask, 8'h0F, "mask after entry restart");

    // R2: idle cycles inside the sequence
    for (int k = 0; k < 6; k++) begin
      do_op("R2", 1'b0, key(k), 8'h00);
      idle_cycle("R2");
    end
    do_op("R2", 1'b1, 17'h1DAAA, 8'h00);
    idle_cycle("R2");
    do_op("R2", 1'b1, 17'h0ECCC, 8'hFF);
    do_op("R2", 1'b1, 17'h0FF00, 8'h00);
    chk("R2", prot_mask, 8'h00, "mask cleared");

    // R9: biased random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit        w;
      bit [16:0] a;
      bit [7:0]  d;
      int        r;
      r = $urandom_range(0, 99);
      if (r < 5) begin
        idle_cycle("R9");
      end else begin
        w = ($urandom_range(0, 99) < 25);
        if ($urandom_range(0, 99) < 70) a = key($urandom_range(0, 5));
        else a = 17'($urandom);
        if (m_st >= 7 && $urandom_range(0, 99) < 70) d = ~m_cand;
        else d = 8'($urandom);
        if (m_st <= 5 && $urandom_range(0, 99) < 80) begin
          w = 1'b0; a = key(m_st);
        end else if (m_st >= 6 && m_st <= 8 && $urandom_range(0, 99) < 80) begin
          w = 1'b1;
        end
        do_op("R9", w, a, d);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule